// File: doc/BRIEF.md
# Serially Configured Sum-of-Products Logic Array

This block models a small fuse-programmable logic device. A plane of AND gates forms product terms from the primary inputs, from their complements and from the outputs of the block's own macrocells. Each macrocell owns a fixed group of product terms and ORs them together. The sum then passes through a programmable inverter. A storage flip-flop captures that value on every active clock. A mode bit chooses whether the pin presents the flip-flop output or the combinational value. A per-pin output enable tells the pad driver whether to drive the pin or to float it.

All fuses sit in one long shift chain. Before operation the chain is filled one bit per clock while the program strobe is high. During that time every pin enable is forced off and the macrocell flip-flops are frozen. Once the strobe drops, the loaded image defines the logic until the next load.

Top module: `pla_array`

## Requirements
- R1: While reset is asserted, every bit of `pin_oe` is 0 and all macrocell flip-flops and configuration bits are cleared.
- R2: While `prog_en` is 1, the configuration chain shifts by one bit per rising edge. `prog_bit` enters at chain index 0 and the contents move toward higher indices, so the first bit shifted lands at the highest index. Macrocell m occupies indices m*195 .. m*195+194. Term t of that macrocell occupies offsets t*24 .. t*24+23. Offset 192 holds the polarity bit, 193 holds the mode bit (1 = registered) and 194 holds the output-enable bit. While `prog_en` is 0, `prog_bit` has no effect and the chain keeps its contents.
- R3: A product term is the AND of its enabled literals. Signal k (0..7 for `pin_in[k]`, 8..11 for the flip-flop of macrocell k-8) gives literal 2k in true form and literal 2k+1 in complemented form. A 1 at offset l of a term enables literal l.
- R4: A product term with no literal enabled evaluates to 1. A term that enables both forms of one signal evaluates to 0.
- R5: Macrocell m ORs product terms 0..7 of its own group, and no other terms.
- R6: A polarity bit of 1 inverts the OR result of its macrocell. A polarity bit of 0 passes the result unchanged.
- R7: In combinational mode `pin_d[m]` follows the inverted-or-not sum within the same cycle. In registered mode `pin_d[m]` shows the flip-flop, which loads that value on each rising edge outside programming.
- R8: The feedback literals of macrocell m always come from its flip-flop. In combinational mode they therefore trail the pin by one clock.
- R9: Outside programming, `pin_oe[m]` equals the macrocell's output-enable bit. While `prog_en` is 1, every bit of `pin_oe` is 0.
- R10: While `prog_en` is 1, the macrocell flip-flops hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for chain and macrocells |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_en | input | 1 | Configuration load strobe |
| prog_bit | input | 1 | Serial configuration data |
| pin_in | input | 8 | Primary logic inputs |
| pin_d | output | 4 | Data presented to each output pad |
| pin_oe | output | 4 | Pad drive enable per output, 0 = high impedance |

## Verification
The bench builds the array with its default sizes: eight inputs, four macrocells and eight terms per macrocell. These sizes give a 780-bit chain that a full load crosses in well under a thousand cycles, so three complete loads fit in one run. Four macrocells are enough to exercise every combination in one image: combinational and registered pins, inverted and plain polarity, an enabled and a floated pin, and a self-toggling registered cell. Another cell reads that toggling cell through feedback, which makes the one-clock feedback lag visible at a pin.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // Macrocell output selection.
  typedef enum logic {
    MC_COMB = 1'b0,
    MC_REG  = 1'b1
  } mc_mode_e;

  // Control bits that follow the term fuses of each macrocell.
  localparam int CTRL_BITS = 3;
  localparam int CTRL_POL  = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_OE   = 2;

  // Literal count: true and complement form of every input and feedback.
  function automatic int lit_count(input int n_in, input int n_mc);
    return 2 * (n_in + n_mc);
  endfunction

endpackage

// File: rtl/pla_rst_sync.sv
`timescale 1ns/1ps
module pla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_ok = sync_q[1];

endmodule

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
module pla_cfg_chain #(
  parameter int W = 780
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] cfg_q
);

  logic [W-1:0] cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (shift_en) begin
      cfg_nxt = {cfg_q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_nxt;
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_LIT = 24,
  parameter int N_PT  = 8
) (
  input  logic [N_LIT-1:0]      lits,
  input  logic [N_PT*N_LIT-1:0] fuse,
  output logic [N_PT-1:0]       terms
);

  // A literal whose fuse is clear is forced to 1; an empty term is thus 1.
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] masked;
    assign masked   = lits | ~fuse[t*N_LIT +: N_LIT];
    assign terms[t] = &masked;
  end

endmodule

// File: rtl/pla_macrocell.sv
`timescale 1ns/1ps
module pla_macrocell
  import pla_pkg::*;
#(
  parameter int N_PT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [N_PT-1:0] terms,
  input  logic            pol,
  input  mc_mode_e        mode,
  output logic            d_val,
  output logic            q,
  output logic            pin
);

  logic sum;
  logic q_nxt;

  always_comb begin
    sum   = |terms;
    d_val = sum ^ pol;
    q_nxt = hold ? q : d_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

  assign pin = (mode == MC_REG) ? q : d_val;

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_en,
  input  logic            prog_bit,
  input  logic [N_IN-1:0] pin_in,
  output logic [N_MC-1:0] pin_d,
  output logic [N_MC-1:0] pin_oe
);

  localparam int N_SIG     = N_IN + N_MC;
  localparam int N_LIT     = lit_count(N_IN, N_MC);
  localparam int TERM_BITS = PT_PER_MC * N_LIT;
  localparam int MC_BITS   = TERM_BITS + CTRL_BITS;
  localparam int CFG_W     = N_MC * MC_BITS;

  logic             rst_ok;
  logic [CFG_W-1:0] cfg_q;
  logic [N_LIT-1:0] lits;
  logic [N_MC-1:0]  fb_q;
  logic [N_MC-1:0]  mc_d;

  pla_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  pla_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_ok),
    .shift_en (prog_en),
    .bit_in   (prog_bit),
    .cfg_q    (cfg_q)
  );

  // Literal bus: signal k gives literal 2k (true) and 2k+1 (complement).
  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    logic sig;
    if (k < N_IN) begin : g_in
      assign sig = pin_in[k];
    end else begin : g_fb
      assign sig = fb_q[k-N_IN];
    end
    assign lits[2*k]   = sig;
    assign lits[2*k+1] = ~sig;
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int BASE = m * MC_BITS;
    logic [PT_PER_MC-1:0] terms;
    logic                 pol;
    logic                 oe_bit;
    mc_mode_e             mode;

    assign pol    = cfg_q[BASE + TERM_BITS + CTRL_POL];
    assign mode   = mc_mode_e'(cfg_q[BASE + TERM_BITS + CTRL_MODE]);
    assign oe_bit = cfg_q[BASE + TERM_BITS + CTRL_OE];

    pla_and_plane #(.N_LIT(N_LIT), .N_PT(PT_PER_MC)) u_and (
      .lits  (lits),
      .fuse  (cfg_q[BASE +: TERM_BITS]),
      .terms (terms)
    );

    pla_macrocell #(.N_PT(PT_PER_MC)) u_cell (
      .clk   (clk),
      .rst_n (rst_ok),
      .hold  (prog_en),
      .terms (terms),
      .pol   (pol),
      .mode  (mode),
      .d_val (mc_d[m]),
      .q     (fb_q[m]),
      .pin   (pin_d[m])
    );

    assign pin_oe[m] = oe_bit & ~prog_en;
  end

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int N_MC = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            prog_en,
  input logic            prog_bit,
  input logic [N_MC-1:0] pin_oe,
  input logic [N_MC-1:0] fb_q,
  input logic [N_MC-1:0] mc_d,
  input logic            cfg_lsb
);

  // R9: pads float during a load
  p_oe_off_prog_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    prog_en |-> (pin_oe == '0));

  // R2: serial bit lands at chain index 0 on the next edge
  p_cfg_shift_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    prog_en |=> (cfg_lsb == $past(prog_bit)));

  // R10: flip-flops frozen while loading
  p_hold_prog_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    prog_en |=> $stable(fb_q));

  // R7, R8: flip-flop loads the macrocell value outside loading
  p_reg_follow_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !prog_en |=> (fb_q == $past(mc_d)));

  // R9: enables do not change while no load is in progress
  p_oe_stable_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!prog_en && $past(!prog_en)) |-> $stable(pin_oe));

endmodule

bind pla_array pla_array_chk #(.N_MC(N_MC)) u_chk (
  .clk     (clk),
  .rst_ok  (rst_ok),
  .prog_en (prog_en),
  .prog_bit(prog_bit),
  .pin_oe  (pin_oe),
  .fb_q    (fb_q),
  .mc_d    (mc_d),
  .cfg_lsb (cfg_q[0])
);

// File: tb/sim_pla_array.sv
`timescale 1ns/1ps
module sim_pla_array;

  localparam int NI  = 8;
  localparam int NM  = 4;
  localparam int PT  = 8;
  localparam int NL  = 2 * (NI + NM);
  localparam int MCB = PT * NL + 3;
  localparam int CW  = NM * MCB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_en;
  logic          prog_bit;
  logic [NI-1:0] pin_in;
  logic [NM-1:0] pin_d;
  logic [NM-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [CW-1:0] img;   // image to load
  logic [CW-1:0] mcfg;  // model of chain
  logic [NM-1:0] mq;    // model of flip-flops

  always #2 clk = ~clk;

  pla_array u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_en),
    .prog_bit (prog_bit),
    .pin_in   (pin_in),
    .pin_d    (pin_d),
    .pin_oe   (pin_oe)
  );

  task automatic chk(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural evaluation of the programmed logic from the requirement text.
  function automatic logic [NM-1:0] model_d(input logic [NI-1:0] inp);
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++) begin
      logic acc = 1'b0;
      for (int t = 0; t < PT; t++) begin
        logic tv = 1'b1;
        for (int l = 0; l < NL; l++) begin
          if (mcfg[m*MCB + t*NL + l]) begin
            int k = l / 2;
            logic s = (k < NI) ? inp[k] : mq[k-NI];
            if (l % 2 == 1) s = ~s;
            tv = tv & s;
          end
        end
        acc = acc | tv;
      end
      r[m] = acc ^ mcfg[m*MCB + PT*NL];
    end
    return r;
  endfunction

  task automatic step(input logic [NI-1:0] inp, input logic pe, input logic pb, input string tag);
    logic [NM-1:0] d, pd, oe;
    @(negedge clk);
    pin_in = inp; prog_en = pe; prog_bit = pb;
    #1;
    d = model_d(inp);
    for (int m = 0; m < NM; m++) begin
      pd[m] = mcfg[m*MCB + PT*NL + 1] ? mq[m] : d[m];
      oe[m] = mcfg[m*MCB + PT*NL + 2] & ~pe;
    end
    chk({tag, " pin_d"}, pin_d, pd);
    chk({tag, " pin_oe"}, pin_oe, oe);
    if (pe) mcfg = {mcfg[CW-2:0], pb};
    else    mq = d;
  endtask

  // R2: highest index shifted first
  task automatic load_image();
    for (int i = CW - 1; i >= 0; i--) begin
      step(8'h00, 1'b1, img[i], "R2 R9 R10 load");
    end
  endtask

  // Every term starts disabled by enabling in0 and its complement (R4).
  task automatic img_clear();
    img = '0;
    for (int m = 0; m < NM; m++)
      for (int t = 0; t < PT; t++) begin
        img[m*MCB + t*NL + 0] = 1'b1;
        img[m*MCB + t*NL + 1] = 1'b1;
      end
  endtask

  task automatic term_set(input int m, input int t, input int l);
    img[m*MCB + t*NL + 0] = 1'b0;
    img[m*MCB + t*NL + 1] = 1'b0;
    if (l >= 0) img[m*MCB + t*NL + l] = 1'b1;
  endtask

  task automatic lit_add(input int m, input int t, input int l);
    img[m*MCB + t*NL + l] = 1'b1;
  endtask

  task automatic ctrl(input int m, input logic pol, input logic rg, input logic oe);
    img[m*MCB + PT*NL + 0] = pol;
    img[m*MCB + PT*NL + 1] = rg;
    img[m*MCB + PT*NL + 2] = oe;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_en = 1'b0; prog_bit = 1'b0; pin_in = '0;
    mcfg = '0; mq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pin_oe", pin_oe, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // empty configuration: every term is 1, so each flip-flop now holds 1
    mq = 4'hF;

    // R2: prog_bit ignored while prog_en low
    for (int i = 0; i < 6; i++) step(8'(i * 37), 1'b0, 1'b1, "R2 idle");

    // Image A
    img_clear();
    term_set(0, 0, 0);  lit_add(0, 0, 3);      // in0 & ~in1   (R3)
    term_set(0, 1, 4);  lit_add(0, 1, 6);      // in2 & in3    (R5)
    ctrl(0, 1'b0, 1'b0, 1'b1);
    term_set(1, 2, 8);  term_set(1, 5, 10);    // in4 | in5, inverted, registered
    ctrl(1, 1'b1, 1'b1, 1'b1);                 // R6 R7
    term_set(2, 7, -1);                        // empty term -> 1 (R4)
    ctrl(2, 1'b0, 1'b0, 1'b0);                 // floated pin (R9)
    term_set(3, 0, 2*11 + 1);                  // ~q3: toggler (R8)
    ctrl(3, 1'b0, 1'b1, 1'b1);
    load_image();
    step(8'h01, 1'b0, 1'b0, "R3 R5");
    step(8'h03, 1'b0, 1'b0, "R3 R5");
    step(8'h0C, 1'b0, 1'b0, "R5");
    step(8'h10, 1'b0, 1'b0, "R6 R7");
    step(8'h20, 1'b0, 1'b0, "R6 R7");
    step(8'h00, 1'b0, 1'b1, "R7 R8");
    for (int i = 0; i < 40; i++)
      step(8'($urandom), 1'b0, 1'($urandom), "R3 R4 R5 R6 R7 R8 R9");

    // Image B: feedback in combinational mode and killed terms
    img_clear();
    ctrl(0, 1'b1, 1'b0, 1'b1);                 // all terms 0, inverted -> 1 (R4 R6)
    term_set(1, 3, 2*11);                      // q3 on a combinational pin (R8)
    ctrl(1, 1'b0, 1'b0, 1'b1);
    term_set(2, 4, -1);                        // empty term, inverted -> 0
    ctrl(2, 1'b1, 1'b0, 1'b1);
    term_set(3, 6, 2*11 + 1);
    ctrl(3, 1'b0, 1'b1, 1'b0);
    load_image();
    for (int i = 0; i < 20; i++)
      step(8'($urandom), 1'b0, 1'b0, "R4 R6 R8 R9");

    // R10: short load burst then resume; flip-flops must not move
    for (int i = 0; i < 5; i++) step(8'hFF, 1'b1, 1'b0, "R10 burst");
    for (int i = 0; i < 10; i++) step(8'($urandom), 1'b0, 1'b0, "R10 after");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule